// File: doc/BRIEF.md
# Effective Address Generator

This unit forms every memory and jump address that the data-movement and control instructions of a 16-bit processor need. It takes the instruction word, the program counter as it stands after fetch (already one past the current instruction) and the value of a base register read from the register file. From them it builds the address-adder sum, the memory-address mux output and the next value of the program counter.

Each instruction is presented as a class code with a `start` pulse. Classes that need memory run through a small sequencer that drives the address, read and write strobes and waits for `mem_ready` on every access. Indirect accesses run as two memory phases. The first reads a pointer from the PC-relative address, and the second performs the load or store at that pointer. At the end, a one-cycle `done` pulse presents the value for the destination register and the selected next PC. The register file and the memory are outside the block.

Class codes on `op_class`: 0 PC-relative access, 1 base-plus-offset access, 2 indirect access, 3 address-only (LEA), 4 trap, 5 conditional branch, 6 register jump, 7 no operation. The offsets come from fixed fields. The 9-bit signed offset is `instr[8:0]`, the 6-bit signed offset is `instr[5:0]` and the trap vector is `instr[7:0]`. The base register index `instr[8:6]` is decoded outside the block, which receives its value on `base_val`.

Top module: `eag_top`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd`, `mem_wr` and `dst_we` are all low.
- R2: Class 0 accesses address `pc_inc + sext(instr[8:0])`. On a load, `dst_val` carries the word read and `dst_we` is high during `done`.
- R3: Class 1 accesses address `base_val + sext(instr[5:0])`. The field `instr[8:6]` plays no part in the sum.
- R4: Class 2 first reads at `pc_inc + sext(instr[8:0])`. It then performs the load or store at the 16-bit word returned by that read.
- R5: Class 3 raises no memory strobe. During `done` it presents `dst_val = pc_inc + sext(instr[8:0])` with `dst_we` high.
- R6: Class 4 reads at the zero-extended `instr[7:0]`, which `mar_out` also shows. During `done`, `next_pc` equals the word read and `dst_we` is low.
- R7: Class 5 gives `next_pc = pc_inc + sext(instr[8:0])` when `br_take` is high at start, and `next_pc = pc_inc` when it is low. No memory strobe is raised.
- R8: Class 6 gives `next_pc = base_val`, and the low offset bits of `instr` are ignored.
- R9: A store (`is_store` high with class 0, 1 or 2) writes `st_data` at the final address, and `dst_we` stays low.
- R10: A strobe stays high with a stable address until `mem_ready`. `mem_rd` and `mem_wr` are never high together. `done` lasts exactly one cycle.
- R11: A `start` pulse while `busy` is high is ignored, and the running operation completes unchanged.
- R12: All address sums wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| op_class | input | 3 | Instruction class code |
| is_store | input | 1 | Access writes rather than reads |
| br_take | input | 1 | Branch condition satisfied |
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | Incremented program counter |
| base_val | input | 16 | Base register value |
| st_data | input | 16 | Data to store |
| mem_rdata | input | 16 | Memory read data |
| mem_ready | input | 1 | Memory phase complete |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Memory write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| adder_out | output | 16 | Address-adder sum |
| mar_out | output | 16 | Memory-address mux output |
| next_pc | output | 16 | Selected next program counter |
| dst_val | output | 16 | Value for the destination register |
| dst_we | output | 1 | Destination write enable |

## Verification
The assertions assume that `mem_ready` rises only while a strobe is high and then lasts one cycle. They also assume the operands do not need to stay stable after `start`, because the block latches them. The bench memory model answers only active strobes, with a chosen latency of zero or more cycles, and drops `mem_ready` at the next falling edge. It pulses `start` only for single cycles. The stray start used for R11 arrives while the unit is known to be busy.

// File: rtl/eag_pkg.sv
// Shared types for the effective address generator.
// Assumes a 3-bit class code driven by the decoder.
package eag_pkg;
    typedef enum logic [2:0] {
        C_PCREL = 3'd0,
        C_BASE  = 3'd1,
        C_IND   = 3'd2,
        C_LEA   = 3'd3,
        C_TRAP  = 3'd4,
        C_BR    = 3'd5,
        C_JMP   = 3'd6,
        C_NOP   = 3'd7
    } op_class_e;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_PTR_READ = 3'd1,
        S_WAIT_PTR = 3'd2,
        S_ACCESS   = 3'd3,
        S_DONE     = 3'd4
    } seq_state_e;
endpackage

// File: rtl/eag_addr_unit.sv
// Address adder and memory-address mux.
// The first operand is the PC or the base register. The second operand is a
// sign-extended 9-bit or 6-bit field, or zero for a register jump.
// The mux passes either the sum or the zero-extended trap vector.
// Purely combinational; the sum wraps at the word width.
module eag_addr_unit
    import eag_pkg::*;
#(
    parameter int W   = 16,
    parameter int O9  = 9,
    parameter int O6  = 6,
    parameter int VEC = 8
) (
    input  op_class_e        cls,
    input  logic [W-1:0]     ir,
    input  logic [W-1:0]     pc,
    input  logic [W-1:0]     base,
    output logic [W-1:0]     sum,
    output logic [W-1:0]     mar
);
    logic [W-1:0] op1, op2;
    logic [W-1:0] sx9, sx6, zvec;

    // Extend the offset fields and the trap vector to full width.
    always_comb begin
        sx9  = {{(W-O9){ir[O9-1]}}, ir[O9-1:0]};
        sx6  = {{(W-O6){ir[O6-1]}}, ir[O6-1:0]};
        zvec = {{(W-VEC){1'b0}}, ir[VEC-1:0]};
    end

    // Pick the adder operands for the class.
    always_comb begin
        op1 = pc;
        op2 = sx9;
        case (cls)
            C_BASE: begin op1 = base; op2 = sx6; end
            C_JMP:  begin op1 = base; op2 = '0;  end
            default: begin op1 = pc; op2 = sx9; end
        endcase
    end

    // Add modulo 2^W and select the memory address source.
    always_comb begin
        sum = op1 + op2;
        mar = (cls == C_TRAP) ? zvec : sum;
    end
endmodule

// File: rtl/eag_pc_sel.sv
// Next-PC mux with three sources: the incremented PC, the address adder
// (taken branch or register jump) and the word on the data bus (trap).
// Assumes the bus word is the one fetched from the trap vector table.
module eag_pc_sel
    import eag_pkg::*;
#(
    parameter int W = 16
) (
    input  op_class_e    cls,
    input  logic         take,
    input  logic [W-1:0] pc_inc,
    input  logic [W-1:0] sum,
    input  logic [W-1:0] bus,
    output logic [W-1:0] npc
);
    // Choose the source of the next program counter.
    always_comb begin
        case (cls)
            C_BR:    npc = take ? sum : pc_inc;
            C_JMP:   npc = sum;
            C_TRAP:  npc = bus;
            default: npc = pc_inc;
        endcase
    end
endmodule

// File: rtl/eag_seq.sv
// Memory sequencer. It takes direct accesses straight to ACCESS and
// indirect ones through a pointer read first. Classes without memory go
// directly to DONE. Each memory phase holds its strobe until ready.
// Assumes ready is only asserted while a strobe is active.
module eag_seq
    import eag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         accept,
    input  op_class_e    cls,
    input  logic         store,
    input  logic [W-1:0] first_addr,
    input  logic [W-1:0] rdata,
    input  logic         ready,
    output logic [W-1:0] addr,
    output logic         rd,
    output logic         wr,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] data
);
    seq_state_e   state_q;
    logic [W-1:0] addr_q, data_q;
    logic         wr_kind;

    // Decide whether the final access writes.
    always_comb wr_kind = store && (cls == C_PCREL || cls == C_BASE || cls == C_IND);

    // Advance the sequencer and capture the pointer and the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (accept) begin
                    addr_q <= first_addr;
                    case (cls)
                        C_PCREL, C_BASE, C_TRAP: state_q <= S_ACCESS;
                        C_IND:                   state_q <= S_PTR_READ;
                        default:                 state_q <= S_DONE;
                    endcase
                end
                S_PTR_READ: if (ready) begin
                    addr_q  <= rdata;
                    state_q <= S_WAIT_PTR;
                end
                S_WAIT_PTR: state_q <= S_ACCESS;
                S_ACCESS: if (ready) begin
                    if (!wr_kind) data_q <= rdata;
                    state_q <= S_DONE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Decode the strobes and status from the state.
    always_comb begin
        addr = addr_q;
        rd   = (state_q == S_PTR_READ) || (state_q == S_ACCESS && !wr_kind);
        wr   = (state_q == S_ACCESS) && wr_kind;
        busy = (state_q != S_IDLE);
        done = (state_q == S_DONE);
        data = data_q;
    end

    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd && wr));
    a_r10_hold_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !ready) |=> (rd && $stable(addr)));
    a_r10_hold_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !ready) |=> (wr && $stable(addr)));
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r4_ptr_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT_PTR) |-> ($past(ready) && addr == $past(rdata)));
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd && !wr));
endmodule

// File: rtl/eag_top.sv
// Effective address generator top. It latches the operands when a start
// is accepted and feeds the live inputs to the adder while idle. It then
// runs the memory sequencer and presents the destination value and the
// next PC during the one-cycle done pulse.
// Assumes start is ignored while busy.
module eag_top
    import eag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [2:0]   op_class,
    input  logic         is_store,
    input  logic         br_take,
    input  logic [W-1:0] instr,
    input  logic [W-1:0] pc_inc,
    input  logic [W-1:0] base_val,
    input  logic [W-1:0] st_data,
    input  logic [W-1:0] mem_rdata,
    input  logic         mem_ready,
    output logic [W-1:0] mem_addr,
    output logic         mem_rd,
    output logic         mem_wr,
    output logic [W-1:0] mem_wdata,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] adder_out,
    output logic [W-1:0] mar_out,
    output logic [W-1:0] next_pc,
    output logic [W-1:0] dst_val,
    output logic         dst_we
);
    op_class_e    cls_q, cls_s;
    logic [W-1:0] ir_q, pc_q, base_q, st_q;
    logic [W-1:0] ir_s, pc_s, base_s;
    logic         store_q, take_q, store_s, accept;
    logic [W-1:0] rd_data;
    logic         is_load;

    // Accept a new operation only when idle.
    always_comb accept = start && !busy;

    // Latch the operands of an accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q   <= C_NOP;
            ir_q    <= '0;
            pc_q    <= '0;
            base_q  <= '0;
            st_q    <= '0;
            store_q <= 1'b0;
            take_q  <= 1'b0;
        end else if (accept) begin
            cls_q   <= op_class_e'(op_class);
            ir_q    <= instr;
            pc_q    <= pc_inc;
            base_q  <= base_val;
            st_q    <= st_data;
            store_q <= is_store;
            take_q  <= br_take;
        end
    end

    // Use the live inputs while idle and the latched copies while busy.
    always_comb begin
        cls_s   = busy ? cls_q   : op_class_e'(op_class);
        ir_s    = busy ? ir_q    : instr;
        pc_s    = busy ? pc_q    : pc_inc;
        base_s  = busy ? base_q  : base_val;
        store_s = busy ? store_q : is_store;
    end

    eag_addr_unit #(.W(W)) addr_i (
        .cls  (cls_s),
        .ir   (ir_s),
        .pc   (pc_s),
        .base (base_s),
        .sum  (adder_out),
        .mar  (mar_out)
    );

    eag_seq #(.W(W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .cls        (cls_s),
        .store      (store_s),
        .first_addr (mar_out),
        .rdata      (mem_rdata),
        .ready      (mem_ready),
        .addr       (mem_addr),
        .rd         (mem_rd),
        .wr         (mem_wr),
        .busy       (busy),
        .done       (done),
        .data       (rd_data)
    );

    eag_pc_sel #(.W(W)) pcsel_i (
        .cls    (cls_q),
        .take   (take_q),
        .pc_inc (pc_q),
        .sum    (adder_out),
        .bus    (rd_data),
        .npc    (next_pc)
    );

    // Form the destination write and the store data.
    always_comb begin
        is_load   = !store_q && (cls_q == C_PCREL || cls_q == C_BASE || cls_q == C_IND);
        dst_we    = done && (is_load || cls_q == C_LEA);
        dst_val   = (cls_q == C_LEA) ? adder_out : rd_data;
        mem_wdata = st_q;
    end

    a_r9_we_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> done);
    a_r11_hold_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(ir_q) && $stable(cls_q)));
    a_r5_lea_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cls_q == C_LEA) |-> (!mem_rd && !mem_wr));
    a_r7_branch_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cls_q == C_BR || cls_q == C_JMP)) |-> (!mem_rd && !mem_wr));
endmodule

// File: tb/eag_top_tb_top.sv
module eag_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_class = 3'd7;
    logic        is_store = 1'b0, br_take = 1'b0;
    logic [15:0] instr = '0, pc_inc = '0, base_val = '0, st_data = '0;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic [15:0] mem_addr, mem_wdata, adder_out, mar_out, next_pc, dst_val;
    logic        mem_rd, mem_wr, busy, done, dst_we;

    int checks = 0, errors = 0;
    int latency = 0, wcnt = 0;
    int n_acc = 0;
    logic [15:0] acc_addr [4];
    logic        acc_wr   [4];
    logic [15:0] mem [logic [15:0]];
    logic [15:0] g_dst_val, g_npc, g_mar;
    logic        g_we;

    always #5 clk = ~clk;

    eag_top dut_i (.*);

    // Memory model: answers an active strobe after `latency` idle cycles.
    always @(negedge clk) begin
        mem_ready = 1'b0;
        if (mem_rd || mem_wr) begin
            if (wcnt >= latency) begin
                mem_ready = 1'b1;
                if (n_acc < 4) begin
                    acc_addr[n_acc] = mem_addr;
                    acc_wr[n_acc]   = mem_wr;
                end
                n_acc++;
                if (mem_wr) mem[mem_addr] = mem_wdata;
                else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 16'h0000;
                wcnt = 0;
            end else wcnt++;
        end else wcnt = 0;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic [15:0] sx9(logic [15:0] i);
        return {{7{i[8]}}, i[8:0]};
    endfunction
    function automatic logic [15:0] sx6(logic [15:0] i);
        return {{10{i[5]}}, i[5:0]};
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one operation and capture the outputs at the done pulse.
    task automatic run_op(logic [2:0] c, logic st, logic tk, logic [15:0] ir,
                          logic [15:0] pc, logic [15:0] bs, logic [15:0] sd,
                          bit stray);
        int guard = 0;
        n_acc = 0;
        @(negedge clk);
        start = 1; op_class = c; is_store = st; br_take = tk;
        instr = ir; pc_inc = pc; base_val = bs; st_data = sd;
        @(negedge clk);
        start = 0;
        if (stray) begin
            start = 1; op_class = 3'd6; instr = 16'hFFFF; base_val = 16'h7777;
            pc_inc = 16'h1111; is_store = 1'b1; st_data = 16'h0BAD;
            @(negedge clk);
            start = 0;
        end
        while (!done && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        if (!done) begin
            errors++;
            $display("FAIL R10: done never rose, actual 0 expected 1");
        end
        g_dst_val = dst_val; g_npc = next_pc; g_we = dst_we; g_mar = mar_out;
        @(negedge clk);
        chk("R10 done one cycle", {15'b0, done}, 16'h0);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 busy", {15'b0, busy}, 0);
        chk("R1 done", {15'b0, done}, 0);
        chk("R1 strobes", {14'b0, mem_rd, mem_wr}, 0);
        chk("R1 dst_we", {15'b0, dst_we}, 0);
    endtask

    task automatic t_pcrel();
        mem[16'h3000] = 16'hBEEF;
        latency = 2;
        run_op(3'd0, 0, 0, 16'h21FF, 16'h3001, 16'h0, 16'h0, 0);
        chk("R2 addr", acc_addr[0], 16'h3001 + sx9(16'h21FF));
        chk("R2 dst_val", g_dst_val, 16'hBEEF);
        chk("R2 dst_we", {15'b0, g_we}, 1);
        chk("R2 one access", 16'(n_acc), 1);
    endtask

    task automatic t_wrap();
        mem[16'h0004] = 16'h4444;
        latency = 0;
        run_op(3'd0, 0, 0, 16'h0005, 16'hFFFF, 16'h0, 16'h0, 0);
        chk("R12 wrap addr", acc_addr[0], 16'h0004);
        chk("R12 wrap data", g_dst_val, 16'h4444);
    endtask

    task automatic t_base();
        mem[16'h3FE0] = 16'h0A0A;
        latency = 1;
        run_op(3'd1, 0, 0, 16'h01E0, 16'h9999, 16'h4000, 16'h0, 0);
        chk("R3 addr", acc_addr[0], 16'h4000 + sx6(16'h01E0));
        chk("R3 dst_val", g_dst_val, 16'h0A0A);
    endtask

    task automatic t_ind();
        mem[16'h3020] = 16'h5000;
        mem[16'h5000] = 16'h1234;
        latency = 1;
        run_op(3'd2, 0, 0, 16'h0010, 16'h3010, 16'h0, 16'h0, 0);
        chk("R4 ptr addr", acc_addr[0], 16'h3020);
        chk("R4 data addr", acc_addr[1], 16'h5000);
        chk("R4 dst_val", g_dst_val, 16'h1234);
        mem[16'h3021] = 16'h5100;
        run_op(3'd2, 1, 0, 16'h0011, 16'h3010, 16'h0, 16'hCAFE, 0);
        chk("R4 R9 ind store addr", acc_addr[1], 16'h5100);
        chk("R9 ind store data", mem[16'h5100], 16'hCAFE);
        chk("R9 store no dst_we", {15'b0, g_we}, 0);
    endtask

    task automatic t_store();
        latency = 0;
        run_op(3'd1, 1, 0, 16'h0003, 16'h0, 16'h2000, 16'h5A5A, 0);
        chk("R9 store addr", acc_addr[0], 16'h2003);
        chk("R9 store wr", {15'b0, acc_wr[0]}, 1);
        chk("R9 store mem", mem[16'h2003], 16'h5A5A);
    endtask

    task automatic t_lea();
        run_op(3'd3, 0, 0, 16'h0100, 16'h3100, 16'h0, 16'h0, 0);
        chk("R5 dst_val", g_dst_val, 16'h3000);
        chk("R5 dst_we", {15'b0, g_we}, 1);
        chk("R5 no access", 16'(n_acc), 0);
    endtask

    task automatic t_trap();
        mem[16'h00A5] = 16'h0400;
        latency = 1;
        run_op(3'd4, 0, 0, 16'h01A5, 16'h3005, 16'h0, 16'h0, 0);
        chk("R6 vector addr", acc_addr[0], 16'h00A5);
        chk("R6 mar_out", g_mar, 16'h00A5);
        chk("R6 next_pc", g_npc, 16'h0400);
        chk("R6 dst_we", {15'b0, g_we}, 0);
    endtask

    task automatic t_branch();
        run_op(3'd5, 0, 1, 16'h01FA, 16'h300A, 16'h0, 16'h0, 0);
        chk("R7 taken", g_npc, 16'h300A + sx9(16'h01FA));
        chk("R7 no access", 16'(n_acc), 0);
        run_op(3'd5, 0, 0, 16'h01FA, 16'h300A, 16'h0, 16'h0, 0);
        chk("R7 not taken", g_npc, 16'h300A);
    endtask

    task automatic t_jmp();
        run_op(3'd6, 0, 0, 16'h003F, 16'h3000, 16'h1234, 16'h0, 0);
        chk("R8 next_pc", g_npc, 16'h1234);
    endtask

    task automatic t_stray();
        mem[16'h3040] = 16'h7E7E;
        latency = 3;
        run_op(3'd0, 0, 0, 16'h0040, 16'h3000, 16'h0, 16'h0, 1);
        chk("R11 addr kept", acc_addr[0], 16'h3040);
        chk("R11 data kept", g_dst_val, 16'h7E7E);
        chk("R11 single access", 16'(n_acc), 1);
        chk("R11 idle after", {15'b0, busy}, 0);
    endtask

    initial begin
        t_reset();
        t_pcrel();
        t_wrap();
        t_base();
        t_ind();
        t_store();
        t_lea();
        t_trap();
        t_branch();
        t_jmp();
        t_stray();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule